// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver (Host Side)

This block sits on the host end of a two-wire, open-collector keyboard link and receives the bytes the keyboard sends. It synchronises the clock and data lines into the system clock domain and samples data on each falling edge of the line clock. It collects an 11-bit frame, checks the start, parity and stop bits, and presents the byte with a one-cycle valid pulse and two error flags.

After every completed frame the block pulls the line clock low, which tells the keyboard to hold off. It keeps the clock low until the consumer pulses a ready input, and this gives the link byte-level flow control. A host transmitter that shares the wires raises `tx_active_i` while it owns the bus. During that time the receiver drops any frame in progress and releases the clock line. A partial frame whose clock stops for longer than a programmable number of system cycles is thrown away.

Top module: `ps2rx_top`

## Requirements
- R1: After reset the clock-hold output is 0 and the valid strobe is 0.
- R2: Data is sampled on each falling edge of the synchronised line clock. A frame is start (0), eight data bits least significant first, parity, then stop. `rx_data_o` carries the eight data bits, with the first one received in bit 0.
- R3: A start bit sampled as 1 is ignored. It produces no valid pulse and no clock hold, and the next frame is received normally.
- R4: `rx_par_err_o` is 1 with the valid pulse when the eight data bits plus the parity bit hold an even number of ones. It is 0 when they hold an odd number.
- R5: `rx_stop_err_o` is 1 with the valid pulse when the stop bit was sampled as 0. It is 0 when the stop bit was 1.
- R6: From the cycle of the valid pulse, the clock-hold output stays 1 until a cycle with `rx_ready_i` high. It is 0 in the cycle after that.
- R7: If `TIMEOUT_CYC` system cycles pass with no falling edge while a frame is partly received, the partial frame is discarded. The next frame is received from its start bit.
- R8: While `tx_active_i` is 1, the receiver gives no valid pulse and does not hold the clock, from the next cycle on. Any partial frame or pending hold is dropped.
- R9: The valid strobe lasts exactly one cycle for each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Line clock as seen on the wire |
| ps2_dat_i | input | 1 | Line data as seen on the wire |
| tx_active_i | input | 1 | Host transmitter owns the bus |
| rx_ready_i | input | 1 | Consumer has taken the byte; releases the hold |
| ps2_clk_hold_o | output | 1 | 1 = pull the line clock low |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe when a frame completes |
| rx_par_err_o | output | 1 | Parity mismatch for the last frame |
| rx_stop_err_o | output | 1 | Stop bit was 0 for the last frame |

## Verification
The assertions assume that the line clock's low and high phases each last several system cycles. They also assume the keyboard starts a frame only while the line clock reads high, so it never clocks against the block's own hold. The stimulus meets both conditions. The keyboard model uses half-bit times of 20 system cycles, and it waits for the wired-AND clock line to read high before starting a frame. Random bytes with randomly corrupted parity or stop bits are mixed with directed cases: a spurious start edge, a stalled partial frame, transmitter ownership, and a long hold.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_HOLD  = 2'd2
  } rx_state_e;

  localparam int unsigned LINES = 2;
  localparam int unsigned LINE_CLK = 0;
  localparam int unsigned LINE_DAT = 1;
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ps2rx_pkg::LINES-1:0]    raw_i,
  output logic [ps2rx_pkg::LINES-1:0]    sync_o
);
  for (genvar g = 0; g < ps2rx_pkg::LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/ps2rx_wdog.sv
module ps2rx_wdog #(
  parameter int unsigned LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic kick_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run_i || kick_i)   cnt <= '0;
    else if (cnt != CW'(LIMIT))  cnt <= cnt + CW'(1);
  end

  assign fire_o = run_i && !kick_i && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/ps2rx_frame.sv
module ps2rx_frame
  import ps2rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              dat_i,
  input  logic              abort_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              stop_err_o,
  output logic              hold_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 2);

  function automatic logic parity_good(input logic [DATA_W-1:0] d, input logic p);
    return (^d) ^ p;
  endfunction

  rx_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      byte_o     <= '0;
      valid_o    <= 1'b0;
      par_err_o  <= 1'b0;
      stop_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (abort_i) begin
        state   <= RX_IDLE;
        bit_cnt <= '0;
      end else begin
        unique case (state)
          RX_IDLE: begin
            if (fall_i && !dat_i) begin
              state   <= RX_SHIFT;
              bit_cnt <= '0;
            end
          end
          RX_SHIFT: begin
            if (fall_i) begin
              if (bit_cnt < CNT_W'(DATA_W)) begin
                shreg   <= {dat_i, shreg[DATA_W-1:1]};
                bit_cnt <= bit_cnt + CNT_W'(1);
              end else if (bit_cnt == CNT_W'(DATA_W)) begin
                par_bit <= dat_i;
                bit_cnt <= bit_cnt + CNT_W'(1);
              end else begin
                byte_o     <= shreg;
                valid_o    <= 1'b1;
                par_err_o  <= !parity_good(shreg, par_bit);
                stop_err_o <= !dat_i;
                state      <= RX_HOLD;
                bit_cnt    <= '0;
              end
            end
          end
          RX_HOLD: begin
            if (ready_i) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign hold_o = (state == RX_HOLD);
  assign busy_o = (state == RX_SHIFT);
endmodule

// File: rtl/ps2rx_top.sv
module ps2rx_top #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ps2_clk_i,
  input  logic              ps2_dat_i,
  input  logic              tx_active_i,
  input  logic              rx_ready_i,
  output logic              ps2_clk_hold_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_par_err_o,
  output logic              rx_stop_err_o
);
  import ps2rx_pkg::*;

  logic [LINES-1:0] line_s;
  logic             clk_prev;
  logic             fall_edge;
  logic             timeout_fire;
  logic             frame_busy;
  logic             frame_abort;

  ps2rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({ps2_dat_i, ps2_clk_i}),
    .sync_o (line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b1;
    else        clk_prev <= line_s[LINE_CLK];
  end

  assign fall_edge   = clk_prev && !line_s[LINE_CLK];
  assign frame_abort = tx_active_i || timeout_fire;

  ps2rx_wdog #(.LIMIT(TIMEOUT_CYC)) wdog_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (frame_busy),
    .kick_i (fall_edge),
    .fire_o (timeout_fire)
  );

  ps2rx_frame #(.DATA_W(DATA_W)) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_i     (fall_edge),
    .dat_i      (line_s[LINE_DAT]),
    .abort_i    (frame_abort),
    .ready_i    (rx_ready_i),
    .byte_o     (rx_data_o),
    .valid_o    (rx_valid_o),
    .par_err_o  (rx_par_err_o),
    .stop_err_o (rx_stop_err_o),
    .hold_o     (ps2_clk_hold_o),
    .busy_o     (frame_busy)
  );
endmodule

// File: rtl/ps2rx_chk.sv
module ps2rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid_o,
  input logic ps2_clk_hold_o,
  input logic rx_ready_i,
  input logic tx_active_i,
  input logic timeout_fire,
  input logic frame_busy
);
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R6
  hold_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> ps2_clk_hold_o);

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_clk_hold_o && !rx_ready_i && !tx_active_i) |=> ps2_clk_hold_o);

  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_clk_hold_o && rx_ready_i) |=> !ps2_clk_hold_o);

  // R8
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active_i |=> (!ps2_clk_hold_o && !rx_valid_o));

  // R7
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fire |=> (!frame_busy && !rx_valid_o));

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!ps2_clk_hold_o && !rx_valid_o);
    end
  end
endmodule

bind ps2rx_top ps2rx_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_valid_o     (rx_valid_o),
  .ps2_clk_hold_o (ps2_clk_hold_o),
  .rx_ready_i     (rx_ready_i),
  .tx_active_i    (tx_active_i),
  .timeout_fire   (timeout_fire),
  .frame_busy     (frame_busy)
);

// File: tb/ps2rx_top_tb_top.sv
`timescale 1ns/1ps
module ps2rx_top_tb_top;
  localparam int unsigned TO_CYC = 3000;
  localparam int unsigned HB     = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kb_clk = 1'b1;
  logic kb_dat = 1'b1;
  logic tx_active = 1'b0;
  logic rdy = 1'b0;
  logic hold;
  logic [7:0] data;
  logic valid, perr, serr;
  logic line_clk;

  int checks = 0;
  int errors = 0;
  int got_n = 0;
  logic [7:0] got_b = '0;
  logic got_p = 1'b0, got_s = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign line_clk = kb_clk & ~hold;

  ps2rx_top #(.DATA_W(8), .SYNC_STAGES(2), .TIMEOUT_CYC(TO_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(line_clk), .ps2_dat_i(kb_dat),
    .tx_active_i(tx_active), .rx_ready_i(rdy), .ps2_clk_hold_o(hold),
    .rx_data_o(data), .rx_valid_o(valid), .rx_par_err_o(perr), .rx_stop_err_o(serr)
  );

  always @(negedge clk) begin
    if (valid) begin
      got_n++;
      got_b = data;
      got_p = perr;
      got_s = serr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic par;
    par = ~(^b);
    if (bad_par) par = ~par;
    return {~bad_stop, par, b, 1'b0};
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [10:0] f, input int nbits);
    while (line_clk !== 1'b1) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      kb_dat = f[i];
      cycles(HB);
      kb_clk = 1'b0;
      cycles(HB);
      kb_clk = 1'b1;
    end
    cycles(HB);
    kb_dat = 1'b1;
  endtask

  task automatic ack();
    rdy = 1'b1;
    cycles(1);
    rdy = 1'b0;
    cycles(3);
  endtask

  task automatic frame_expect(input logic [7:0] b, input bit bp, input bit bs, input string tag);
    int n0;
    n0 = got_n;
    send_bits(mk_frame(b, bp, bs), 11);
    cycles(5);
    check(got_n == n0 + 1, {tag, " R9 one pulse"}, got_n - n0, 1);
    check(got_b == b, {tag, " R2 byte"}, got_b, b);
    check(got_p == bp, {tag, " R4 parity flag"}, got_p, bp);
    check(got_s == bs, {tag, " R5 stop flag"}, got_s, bs);
    check(hold == 1'b1, {tag, " R6 hold after frame"}, hold, 1);
    ack();
    check(hold == 1'b0, {tag, " R6 released"}, hold, 0);
  endtask

  initial begin
    int n0;
    void'($urandom(32'h5eed_0042));
    cycles(4);
    check(hold == 1'b0, "R1 hold in reset", hold, 0);
    check(valid == 1'b0, "R1 valid in reset", valid, 0);
    rst_n = 1'b1;
    cycles(4);
    check(hold == 1'b0 && got_n == 0, "R1 idle after reset", hold, 0);

    // R2 R6: directed byte and a long hold
    n0 = got_n;
    send_bits(mk_frame(8'hA5, 1'b0, 1'b0), 11);
    cycles(5);
    check(got_b == 8'hA5, "R2 directed byte", got_b, 8'hA5);
    check(got_n == n0 + 1, "R9 directed pulse", got_n - n0, 1);
    cycles(300);
    check(hold == 1'b1, "R6 hold persists without ready", hold, 1);
    ack();
    check(hold == 1'b0, "R6 hold released after ready", hold, 0);

    frame_expect(8'h00, 1'b0, 1'b0, "zero byte");
    frame_expect(8'hFF, 1'b1, 1'b0, "ones bad parity R4");
    frame_expect(8'h80, 1'b0, 1'b1, "bad stop R5");

    for (int k = 0; k < 24; k++) begin
      logic [7:0] b;
      bit bp, bs;
      b  = 8'($urandom);
      bp = ($urandom % 4) == 0;
      bs = ($urandom % 4) == 0;
      frame_expect(b, bp, bs, "random");
    end

    // R3: spurious falling edge with data high
    n0 = got_n;
    send_bits(11'h7FF, 1);
    cycles(10);
    check(got_n == n0, "R3 no valid on start 1", got_n - n0, 0);
    check(hold == 1'b0, "R3 no hold on start 1", hold, 0);
    frame_expect(8'h3C, 1'b0, 1'b0, "R3 after ignored start");

    // R7: stalled partial frame
    n0 = got_n;
    send_bits(mk_frame(8'h00, 1'b0, 1'b0), 5);
    cycles(TO_CYC + 100);
    check(got_n == n0 && hold == 1'b0, "R7 no output after stall", got_n - n0, 0);
    frame_expect(8'hC3, 1'b0, 1'b0, "R7 after timeout");

    // R8: transmitter owns the bus
    tx_active = 1'b1;
    cycles(2);
    n0 = got_n;
    send_bits(mk_frame(8'h5A, 1'b0, 1'b0), 11);
    cycles(5);
    check(got_n == n0, "R8 no valid while tx active", got_n - n0, 0);
    check(hold == 1'b0, "R8 no hold while tx active", hold, 0);
    tx_active = 1'b0;
    cycles(5);
    frame_expect(8'h96, 1'b0, 1'b0, "R8 after tx");

    // R8: transmitter takes the bus during a hold
    send_bits(mk_frame(8'h11, 1'b0, 1'b0), 11);
    cycles(5);
    check(hold == 1'b1, "R8 hold before tx", hold, 1);
    tx_active = 1'b1;
    cycles(2);
    check(hold == 1'b0, "R8 hold dropped by tx", hold, 0);
    tx_active = 1'b0;
    cycles(5);
    frame_expect(8'h7E, 1'b0, 1'b0, "R8 resume");

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule